// File: doc/BRIEF.md
# Cache Region Address Remapper

This block sits on the address path between a bus master and an instruction cache. It holds a small set of programmable address windows. Each incoming address is compared against every active window. When a window matches, the upper part of the address is replaced by that window's programmed target and the in-window offset passes through unchanged. When nothing matches, the address leaves the block untouched.

Each window has its own size. The size is 2 MB times a power of two, so the boundary between compared bits and kept bits moves with the window. Windows may only be placed in the low 512 MB of the input space. Each window also carries a burst-type bit. When that bit is set, a hit is marked as a 16-byte line fill, issued as an INCR4 burst of four 32-bit beats starting at the line-aligned address.

Window configuration can be written only while the cache is off. The remapping itself keeps running whatever the cache state. The output is combinational from the registered configuration, so it adds no latency to the address phase.

Top module: `remap_unit`

## Requirements
- R1: On a hit, addr_out[31:S] equals the window's target field at those positions and addr_out[S-1:0] equals addr_in[S-1:0]. S is the window's split position.
- R2: Size code c (cfg_wdata[3:1]) with c from 1 to 7 gives S = 20 + c, so the window size runs from 2 MB to 128 MB.
- R3: A window matches only when addr_in[31:29] is 000 and addr_in[28:S] equals the base field at those positions. The base field is cfg_wdata[11:4] and covers address bits 28..21.
- R4: Base and target bits below position S have no effect on matching or on the output address. The target field is cfg_wdata[22:12] and covers address bits 31..21.
- R5: A window whose enable bit (cfg_wdata[0]) is 0, or whose size code is 0, never matches.
- R6: When several windows match, the lowest-numbered one supplies the output address and the burst type.
- R7: When no window matches, addr_out equals addr_in, region_hit is 0, line_burst is 0 and fill_addr equals addr_in.
- R8: A write with cfg_we=1 and cache_on=0 loads window cfg_sel, and the new setting is seen from the next cycle. A write made while cache_on=1 leaves every window unchanged.
- R9: Remapping results are the same whether cache_on is 0 or 1.
- R10: On a hit, line_burst equals the window's burst bit (cfg_wdata[23]). fill_addr equals addr_out with bits [3:0] cleared when line_burst is 1, and equals addr_out otherwise.
- R11: addr_out, region_hit, line_burst and fill_addr follow addr_in in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; all windows cleared |
| cache_on | input | 1 | Cache enabled; blocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Window number to write |
| cfg_wdata | input | 24 | Window setting: enable, size code, base, target, burst bit |
| addr_in | input | 32 | Incoming address |
| addr_out | output | 32 | Remapped or passed-through address |
| region_hit | output | 1 | An active window matched |
| line_burst | output | 1 | Access is an INCR4 line fill |
| fill_addr | output | 32 | Burst start address (line-aligned on a line fill) |

## Verification
A configuration write is captured at the rising edge where cfg_we is high. The bench drives it at a falling edge, holds it across one rising edge and drops it at the next falling edge. From then on every address check uses the new setting. The address outputs have zero cycles of delay. The bench therefore changes addr_in at a falling edge and samples all four outputs 1 ns later, well before the next rising edge. It compares them with a model built only from the bit-level rules above.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int ADDR_W    = 32;
    localparam int MIN_SPLIT = 21;               // 2 MB window
    localparam int BASE_W    = 29 - MIN_SPLIT;   // address bits 28..21
    localparam int TGT_W     = ADDR_W - MIN_SPLIT; // address bits 31..21
    localparam int SZ_W      = 3;
    localparam int LINE_LSB  = 4;                // 16-byte line

    typedef struct packed {
        logic              line_fill;  // [23]
        logic [TGT_W-1:0]  tgt_hi;     // [22:12]
        logic [BASE_W-1:0] base_hi;    // [11:4]
        logic [SZ_W-1:0]   szc;        // [3:1]
        logic              on;         // [0]
    } win_cfg_t;

    localparam int CFG_W = $bits(win_cfg_t);
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
    import remap_pkg::*;
#(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cache_on,
    input  logic               we,
    input  logic [IDX_W-1:0]   sel,
    input  win_cfg_t           wdata,
    output win_cfg_t [N-1:0]   cfg
);
    typedef struct packed {
        win_cfg_t [N-1:0] win;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && !cache_on) begin
            for (int i = 0; i < N; i++) begin
                if (sel == IDX_W'(i)) st_d.win[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.win;
endmodule

// File: rtl/remap_region_match.sv
module remap_region_match
    import remap_pkg::*;
(
    input  win_cfg_t            cfg,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [ADDR_W-1:0]   mapped
);
    logic [4:0]        split;
    logic [ADDR_W-1:0] hi_mask;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] tgt_full;

    always_comb begin
        split     = 5'(MIN_SPLIT - 1) + {2'b00, cfg.szc};
        hi_mask   = ~((32'd1 << split) - 32'd1);
        base_full = {3'b000, cfg.base_hi, {MIN_SPLIT{1'b0}}};
        tgt_full  = {cfg.tgt_hi, {MIN_SPLIT{1'b0}}};
        hit       = cfg.on && (cfg.szc != '0)
                    && ((addr & hi_mask) == (base_full & hi_mask));
        mapped    = (tgt_full & hi_mask) | (addr & ~hi_mask);
    end
endmodule

// File: rtl/remap_pick.sv
module remap_pick
    import remap_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]        hit_vec,
    input  logic [ADDR_W-1:0]   mapped [N],
    input  logic [N-1:0]        fill_vec,
    input  logic [ADDR_W-1:0]   addr,
    output logic                any_hit,
    output logic [ADDR_W-1:0]   sel_addr,
    output logic                sel_fill
);
    always_comb begin
        any_hit  = 1'b0;
        sel_addr = addr;
        sel_fill = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit  = 1'b1;
                sel_addr = mapped[i];
                sel_fill = fill_vec[i];
            end
        end
    end
endmodule

// File: rtl/remap_unit.sv
module remap_unit
    import remap_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cache_on,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic [ADDR_W-1:0]   addr_in,
    output logic [ADDR_W-1:0]   addr_out,
    output logic                region_hit,
    output logic                line_burst,
    output logic [ADDR_W-1:0]   fill_addr
);
    win_cfg_t [NUM_WIN-1:0] cfg_q;
    logic [NUM_WIN-1:0]     hit_vec;
    logic [NUM_WIN-1:0]     fill_vec;
    logic [ADDR_W-1:0]      mapped [NUM_WIN];

    remap_cfg_regs #(.N(NUM_WIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cache_on (cache_on),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (win_cfg_t'(cfg_wdata)),
        .cfg      (cfg_q)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        remap_region_match u_match (
            .cfg    (cfg_q[g]),
            .addr   (addr_in),
            .hit    (hit_vec[g]),
            .mapped (mapped[g])
        );
        assign fill_vec[g] = cfg_q[g].line_fill;
    end

    remap_pick #(.N(NUM_WIN)) u_pick (
        .hit_vec  (hit_vec),
        .mapped   (mapped),
        .fill_vec (fill_vec),
        .addr     (addr_in),
        .any_hit  (region_hit),
        .sel_addr (addr_out),
        .sel_fill (line_burst)
    );

    assign fill_addr = line_burst ? {addr_out[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}}
                                  : addr_out;
endmodule

// File: rtl/remap_unit_chk.sv
module remap_unit_chk
    import remap_pkg::*;
#(
    parameter int N = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cache_on,
    input logic                cfg_we,
    input logic [ADDR_W-1:0]   addr_in,
    input logic [ADDR_W-1:0]   addr_out,
    input logic                region_hit,
    input logic                line_burst,
    input logic [ADDR_W-1:0]   fill_addr,
    input win_cfg_t [N-1:0]    cfg_q
);
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        region_hit |-> addr_out[MIN_SPLIT-1:0] == addr_in[MIN_SPLIT-1:0]); // R1
    AST_LOW_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        region_hit |-> addr_in[31:29] == 3'b000); // R3
    AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !region_hit |-> (addr_out == addr_in) && !line_burst); // R7
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_on && cfg_we) |=> $stable(cfg_q)); // R8
    AST_FILL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        line_burst |-> (fill_addr[LINE_LSB-1:0] == '0)
                       && (fill_addr[31:LINE_LSB] == addr_out[31:LINE_LSB])); // R10
    AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !line_burst |-> fill_addr == addr_out); // R10
endmodule

bind remap_unit remap_unit_chk #(.N(NUM_WIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cache_on   (cache_on),
    .cfg_we     (cfg_we),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .region_hit (region_hit),
    .line_burst (line_burst),
    .fill_addr  (fill_addr),
    .cfg_q      (cfg_q)
);

// File: tb/test_remap_unit.sv
`timescale 1ns/1ps
module test_remap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_on = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [23:0] cfg_wdata = '0;
    logic [31:0] addr_in = '0;
    logic [31:0] addr_out, fill_addr;
    logic        region_hit, line_burst;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] mdl [4];

    always #5 clk = ~clk;

    remap_unit i_remap_unit (
        .clk(clk), .rst_n(rst_n), .cache_on(cache_on), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .addr_in(addr_in),
        .addr_out(addr_out), .region_hit(region_hit),
        .line_burst(line_burst), .fill_addr(fill_addr)
    );

    function automatic logic [33:0] model(input logic [31:0] a);
        for (int i = 0; i < 4; i++) begin
            logic [2:0] c = mdl[i][3:1];
            int s = 20 + int'(c);
            logic [31:0] b = {3'b000, mdl[i][11:4], 21'd0};
            logic [31:0] t = {mdl[i][22:12], 21'd0};
            if (mdl[i][0] && c != 0 && (a >> s) == (b >> s)) begin
                logic [31:0] lo = a & ((32'd1 << s) - 1);
                return {1'b1, mdl[i][23], ((t >> s) << s) | lo};
            end
        end
        return {2'b00, a};
    endfunction

    task automatic wr(input int idx, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!cache_on) mdl[idx] = d;
    endtask

    task automatic chk(input string tag, input logic [31:0] a);
        logic [33:0] e;
        logic [31:0] ef;
        @(negedge clk);
        addr_in = a;
        #1;
        e  = model(a);
        ef = e[32] ? {e[31:4], 4'h0} : e[31:0];
        n_chk++;
        if (addr_out !== e[31:0] || region_hit !== e[33] ||
            line_burst !== e[32] || fill_addr !== ef) begin
            n_bad++;
            $display("FAIL %s addr=%h got out=%h hit=%b lb=%b fill=%h exp out=%h hit=%b lb=%b fill=%h",
                     tag, a, addr_out, region_hit, line_burst, fill_addr,
                     e[31:0], e[33], e[32], ef);
        end
    endtask

    function automatic logic [23:0] mk(input logic fl, input logic [10:0] t,
                                       input logic [7:0] b, input logic [2:0] c,
                                       input logic en);
        return {fl, t, b, c, en};
    endfunction

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        chk("R7 reset pass-through", 32'h0012_3456);
        chk("R7 reset pass-through high", 32'hFFFF_FFF0);
        // 128 MB window, junk base/target bits below the split
        wr(0, mk(1'b0, 11'b00010_111111, 8'b01_111111, 3'd7, 1'b1));
        chk("R1 R2 R4 128MB hit", 32'h0812_3456);
        n_chk++;
        if (addr_out !== 32'h1012_3456) begin
            n_bad++;
            $display("FAIL R4 got %h exp %h", addr_out, 32'h1012_3456);
        end
        chk("R3 above 512MB miss", 32'h2812_3456);
        chk("R3 outside window", 32'h0012_3456);
        // 2 MB window with line fill at region 1
        wr(1, mk(1'b1, 11'h7A5, 8'h33, 3'd1, 1'b1));
        chk("R2 R10 2MB line fill", {3'b000, 8'h33, 21'h1ABCDF});
        chk("R2 2MB neighbour miss", {3'b000, 8'h34, 21'h000004});
        // overlapping lower window wins
        wr(2, mk(1'b1, 11'h111, 8'h33, 3'd1, 1'b1));
        wr(0, mk(1'b0, 11'h222, 8'h30, 3'd3, 1'b1));
        chk("R6 lowest window wins", {3'b000, 8'h33, 21'h000123});
        // disabled by size code 0, or by the enable bit
        wr(0, mk(1'b0, 11'h222, 8'h30, 3'd0, 1'b1));
        chk("R5 size code zero", {3'b000, 8'h33, 21'h000123});
        wr(1, mk(1'b1, 11'h7A5, 8'h33, 3'd1, 1'b0));
        chk("R5 enable low", {3'b000, 8'h33, 21'h000123});
        // writes locked while the cache is on, remapping still runs
        @(negedge clk); cache_on = 1'b1;
        wr(2, mk(1'b0, 11'h000, 8'h00, 3'd7, 1'b1));
        chk("R8 R9 locked write ignored", {3'b000, 8'h33, 21'h000123});
        chk("R8 locked write no new window", 32'h0000_1000);
        @(negedge clk); cache_on = 1'b0;
        wr(2, mk(1'b0, 11'h000, 8'h00, 3'd7, 1'b1));
        chk("R8 unlocked write takes effect", 32'h0000_1000);
        // random
        for (int it = 0; it < 600; it++) begin
            int r = int'($urandom_range(0, 9));
            if (r == 0) begin
                @(negedge clk); cache_on = $urandom_range(0, 1) == 1;
                wr(int'($urandom_range(0, 3)), 24'($urandom));
            end else begin
                int w = int'($urandom_range(0, 3));
                logic [31:0] a = $urandom;
                if (r < 7) a = {3'b000, mdl[w][11:4], a[20:0]};
                chk(cache_on ? "R9 R11 random on" : "R1 R11 random off", a);
            end
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule